// File: doc/BRIEF.md
# Oversampled Serial Character Receiver

This block turns an asynchronous serial line into stored characters. An external strobe, `baud_tick`, pulses at sixteen times the bit rate. The receiver resynchronises the line and finds the falling edge of a start bit. It confirms that start bit half a bit later, then samples every data bit, the optional parity bit and the stop bit at the middle of each bit. The host selects a character length of five to eight bits and one of several parity rules. Both settings are held steady while a character is on the line.

Each finished character goes into a four-entry first-in first-out buffer. The entry carries three status bits for that character: parity error, framing error and break. The host sees the oldest entry on the read port while `rd_valid` is high and removes it with a one-cycle `rd_en` pulse. A character that arrives while the buffer is full is lost, and a sticky overrun flag is raised. A line held low for a whole character is stored once as a break. The receiver then waits for the line to return high before it looks for the next start bit.

Top module: `srx_top`

## Requirements
- R1: After reset `rd_valid` and `ovr_flag` are 0.
- R2: `cfg_len` selects the data length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Bits arrive LSB first. Bit 0 of `rd_data` holds the first data bit, and bits above the length read 0.
- R3: `cfg_par` selects the parity rule: 0 none, 1 even, 2 odd, 3 forced 0, 4 forced 1, and 5 to 7 none. With parity on, a parity bit follows the last data bit. `rd_perr` is 1 when that bit differs from the rule. Under even parity the total count of ones is even; under odd parity it is odd.
- R4: A stop bit sampled low flags `rd_ferr`, unless the character is a break.
- R5: A low pulse on the line that ends before the middle of the start bit is a false start: nothing is stored.
- R6: When the data bits, the parity bit (if enabled) and the stop bit are all low, exactly one entry is stored with data 0, `rd_brk`=1 and both error bits 0. No further entry is stored until the line has gone high.
- R7: A break that begins partway through a character produces that character with `rd_ferr`=1, followed by one break entry.
- R8: The buffer holds four characters in arrival order. The head entry stays unchanged until `rd_en` removes it.
- R9: A character that completes while four entries are held, with no read in that cycle, is discarded and sets `ovr_flag`. The stored entries are kept. `ovr_flag` stays 1 until `ovr_clr` is pulsed.
- R10: The parity and framing status bits are kept with their own character through the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | Strobe at sixteen times the bit rate |
| rxd_in | input | 1 | Serial line, idles high |
| cfg_len | input | 2 | Data length select |
| cfg_par | input | 3 | Parity rule select |
| rd_en | input | 1 | Remove head entry |
| rd_valid | output | 1 | Buffer not empty |
| rd_data | output | 8 | Head character |
| rd_perr | output | 1 | Head parity error |
| rd_ferr | output | 1 | Head framing error |
| rd_brk | output | 1 | Head is a break |
| ovr_flag | output | 1 | Sticky overrun |
| ovr_clr | input | 1 | Clear overrun |

## Verification
The assertions assume the host raises `rd_en` only for single cycles. They also assume that `ovr_clr` is pulsed only when no character is completing in the same cycle. The assertions place no limit on the serial line. The data-path checks do assume that `cfg_len` and `cfg_par` stay fixed for the length of a character. The stimulus changes the configuration only while the line is idle between frames. It pulses `rd_en` for single cycles from the monitor, and it pulses `ovr_clr` only after the buffer has drained with the line idle.

// File: rtl/srx_pkg.sv
package srx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_HOLD
    } srx_state_e;

    typedef struct packed {
        logic [7:0] data;
        logic       perr;
        logic       ferr;
        logic       brk;
    } srx_entry_t;

    localparam logic [2:0] PAR_NONE  = 3'd0;
    localparam logic [2:0] PAR_EVEN  = 3'd1;
    localparam logic [2:0] PAR_ODD   = 3'd2;
    localparam logic [2:0] PAR_LOW   = 3'd3;
    localparam logic [2:0] PAR_HIGH  = 3'd4;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    typedef struct packed {
        logic [STAGES-1:0] pipe;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d      = sync_q;
        sync_d.pipe = {sync_q.pipe[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '{pipe: '1};
        else        sync_q <= sync_d;
    end

    assign dout = sync_q.pipe[STAGES-1];
endmodule

// File: rtl/srx_framer.sv
module srx_framer
    import srx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rxd,
    input  logic [1:0] cfg_len,
    input  logic [2:0] cfg_par,
    output logic       push,
    output srx_entry_t entry
);
    localparam int CW = $clog2(OSR);
    localparam logic [CW-1:0] LAST_TICK = CW'(OSR - 1);
    localparam logic [CW-1:0] MID_TICK  = CW'(OSR / 2 - 1);

    typedef struct packed {
        srx_state_e state;
        logic [CW-1:0] cnt;
        logic [2:0] idx;
        logic [7:0] shreg;
        logic       parbit;
        logic       push;
        srx_entry_t entry;
    } fr_t;

    fr_t fr_d, fr_q;

    logic       par_en;
    logic       par_exp;
    logic       all_low;
    logic [2:0] last_idx;

    always_comb begin
        par_en   = (cfg_par >= PAR_EVEN) && (cfg_par <= PAR_HIGH);
        last_idx = 3'(cfg_len) + 3'd4;
        case (cfg_par)
            PAR_EVEN: par_exp = ^fr_q.shreg;
            PAR_ODD:  par_exp = ~^fr_q.shreg;
            PAR_HIGH: par_exp = 1'b1;
            default:  par_exp = 1'b0;
        endcase
        all_low = (fr_q.shreg == 8'd0) && !(par_en && fr_q.parbit) && !rxd;

        fr_d      = fr_q;
        fr_d.push = 1'b0;
        case (fr_q.state)
            ST_IDLE: if (tick && !rxd) begin
                fr_d.state = ST_START;
                fr_d.cnt   = '0;
            end
            ST_START: if (tick) begin
                if (fr_q.cnt == MID_TICK) begin
                    fr_d.cnt   = '0;
                    fr_d.idx   = '0;
                    fr_d.shreg = '0;
                    fr_d.state = rxd ? ST_IDLE : ST_DATA;
                end else begin
                    fr_d.cnt = fr_q.cnt + 1'b1;
                end
            end
            ST_DATA: if (tick) begin
                if (fr_q.cnt == LAST_TICK) begin
                    fr_d.cnt = '0;
                    fr_d.shreg[fr_q.idx] = rxd;
                    if (fr_q.idx == last_idx) fr_d.state = par_en ? ST_PAR : ST_STOP;
                    else                      fr_d.idx = fr_q.idx + 1'b1;
                end else begin
                    fr_d.cnt = fr_q.cnt + 1'b1;
                end
            end
            ST_PAR: if (tick) begin
                if (fr_q.cnt == LAST_TICK) begin
                    fr_d.cnt    = '0;
                    fr_d.parbit = rxd;
                    fr_d.state  = ST_STOP;
                end else begin
                    fr_d.cnt = fr_q.cnt + 1'b1;
                end
            end
            ST_STOP: if (tick) begin
                if (fr_q.cnt == LAST_TICK) begin
                    fr_d.cnt        = '0;
                    fr_d.push       = 1'b1;
                    fr_d.entry.brk  = all_low;
                    fr_d.entry.data = all_low ? 8'd0 : fr_q.shreg;
                    fr_d.entry.ferr = !rxd && !all_low;
                    fr_d.entry.perr = !all_low && par_en && (fr_q.parbit != par_exp);
                    fr_d.state      = all_low ? ST_HOLD : ST_IDLE;
                end else begin
                    fr_d.cnt = fr_q.cnt + 1'b1;
                end
            end
            ST_HOLD: if (tick && rxd) fr_d.state = ST_IDLE;
            default: fr_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fr_q <= '{state: ST_IDLE, default: '0};
        else        fr_q <= fr_d;
    end

    assign push  = fr_q.push;
    assign entry = fr_q.entry;
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo
    import srx_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  srx_entry_t wdata,
    input  logic       pop,
    input  logic       ovr_clr,
    output srx_entry_t rdata,
    output logic       valid,
    output logic [$clog2(DEPTH):0] count,
    output logic       ovr
);
    localparam int PW = $clog2(DEPTH);
    localparam logic [PW:0]   FULL_CNT = (PW+1)'(DEPTH);
    localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);

    typedef struct packed {
        srx_entry_t [DEPTH-1:0] mem;
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [PW:0]   cnt;
        logic          ovr;
    } fifo_t;

    fifo_t ff_d, ff_q;
    logic pop_ok, accept;

    always_comb begin
        pop_ok = pop && (ff_q.cnt != '0);
        accept = push && ((ff_q.cnt != FULL_CNT) || pop_ok);
        ff_d   = ff_q;
        if (pop_ok) ff_d.rp = (ff_q.rp == LAST_PTR) ? '0 : ff_q.rp + 1'b1;
        if (accept) begin
            ff_d.mem[ff_q.wp] = wdata;
            ff_d.wp = (ff_q.wp == LAST_PTR) ? '0 : ff_q.wp + 1'b1;
        end
        ff_d.cnt = ff_q.cnt + (PW+1)'(accept) - (PW+1)'(pop_ok);
        if (push && !accept) ff_d.ovr = 1'b1;
        else if (ovr_clr)    ff_d.ovr = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff_q <= '0;
        else        ff_q <= ff_d;
    end

    assign rdata = ff_q.mem[ff_q.rp];
    assign valid = (ff_q.cnt != '0);
    assign count = ff_q.cnt;
    assign ovr   = ff_q.ovr;
endmodule

// File: rtl/srx_top.sv
module srx_top
    import srx_pkg::*;
#(
    parameter int OSR   = 16,
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       baud_tick,
    input  logic       rxd_in,
    input  logic [1:0] cfg_len,
    input  logic [2:0] cfg_par,
    input  logic       rd_en,
    output logic       rd_valid,
    output logic [7:0] rd_data,
    output logic       rd_perr,
    output logic       rd_ferr,
    output logic       rd_brk,
    output logic       ovr_flag,
    input  logic       ovr_clr
);
    logic       rxd_s;
    logic       frm_push;
    srx_entry_t frm_entry;
    srx_entry_t head;
    logic [$clog2(DEPTH):0] fifo_count;

    srx_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(rxd_in), .dout(rxd_s)
    );

    srx_framer #(.OSR(OSR)) u_framer (
        .clk(clk), .rst_n(rst_n), .tick(baud_tick), .rxd(rxd_s),
        .cfg_len(cfg_len), .cfg_par(cfg_par),
        .push(frm_push), .entry(frm_entry)
    );

    srx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(frm_push), .wdata(frm_entry),
        .pop(rd_en), .ovr_clr(ovr_clr), .rdata(head), .valid(rd_valid),
        .count(fifo_count), .ovr(ovr_flag)
    );

    assign rd_data = head.data;
    assign rd_perr = head.perr;
    assign rd_ferr = head.ferr;
    assign rd_brk  = head.brk;
endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
    parameter int DEPTH = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_en,
    input logic       rd_valid,
    input logic [7:0] rd_data,
    input logic       rd_perr,
    input logic       rd_ferr,
    input logic       rd_brk,
    input logic       ovr_flag,
    input logic       ovr_clr,
    input logic       push,
    input logic [$clog2(DEPTH):0] count
);
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= ($clog2(DEPTH)+1)'(DEPTH));                                   // R8
    AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_en |=> rd_valid && $stable({rd_data, rd_perr, rd_ferr, rd_brk})); // R8
    AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        push && (count == ($clog2(DEPTH)+1)'(DEPTH)) && !rd_en |=> ovr_flag);  // R9
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_flag && !ovr_clr |=> ovr_flag);                                    // R9
    AST_BRK_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && rd_brk |-> (rd_data == 8'd0) && !rd_ferr && !rd_perr);    // R6
endmodule

bind srx_top srx_checker #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_perr(rd_perr), .rd_ferr(rd_ferr), .rd_brk(rd_brk),
    .ovr_flag(ovr_flag), .ovr_clr(ovr_clr), .push(frm_push), .count(fifo_count)
);

// File: tb/srx_top_test.sv
module srx_top_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b1;
    logic       rxd_in = 1'b1;
    logic [1:0] cfg_len = 2'd3;
    logic [2:0] cfg_par = 3'd0;
    logic       rd_en = 1'b0;
    logic       ovr_clr = 1'b0;
    logic       rd_valid, rd_perr, rd_ferr, rd_brk, ovr_flag;
    logic [7:0] rd_data;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  mon_en = 1'b1;
    bit  done = 1'b0;
    logic [10:0] expq[$];   // {tag[10:11]..} packed as {data,perr,ferr,brk}

    always #2 clk = ~clk;

    srx_top uut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rxd_in(rxd_in),
        .cfg_len(cfg_len), .cfg_par(cfg_par), .rd_en(rd_en),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_perr(rd_perr),
        .rd_ferr(rd_ferr), .rd_brk(rd_brk), .ovr_flag(ovr_flag), .ovr_clr(ovr_clr)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic drive_bit(input logic b);
        rxd_in = b;
        repeat (16) @(negedge clk);
    endtask

    // Drive a full frame; push the expected entry when keep is set.
    task automatic send(input logic [7:0] d, input int len, input int pm,
                        input bit bad_par, input bit stop_hi, input bit keep);
        logic [7:0] m;
        logic p;
        bit pen;
        m = d & 8'((1 << len) - 1);
        cfg_len = 2'(len - 5);
        cfg_par = 3'(pm);
        pen = (pm >= 1) && (pm <= 4);
        case (pm)
            1: p = ^m;
            2: p = ~^m;
            4: p = 1'b1;
            default: p = 1'b0;
        endcase
        if (keep) expq.push_back({m, bad_par && pen, !stop_hi, 1'b0});
        drive_bit(1'b0);
        for (int i = 0; i < len; i++) drive_bit(m[i]);
        if (pen) drive_bit(p ^ bad_par);
        drive_bit(stop_hi);
        drive_bit(1'b1);
        drive_bit(1'b1);
    endtask

    // Monitor: compare head against scoreboard and pop it with one-cycle rd_en.
    initial begin
        forever begin
            @(negedge clk);
            if (rd_en) rd_en = 1'b0;
            else if (mon_en && rst_n && rd_valid) begin
                logic [10:0] got;
                got = {rd_data, rd_perr, rd_ferr, rd_brk};
                if (expq.size() == 0) check(1'b0, "R8 unexpected entry", got, 0);
                else begin
                    logic [10:0] e;
                    e = expq.pop_front();
                    check(got == e, "R2/R3/R4/R6/R10 entry", got, e);
                end
                rd_en = 1'b1;
            end
        end
    end

    task automatic drain();
        for (int i = 0; i < 400 && (expq.size() != 0 || rd_valid || rd_en); i++) @(negedge clk);
        check(expq.size() == 0, "R8 all expected seen", expq.size(), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++; n_cmp++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(rd_valid == 1'b0, "R1 rd_valid", rd_valid, 0);
        check(ovr_flag == 1'b0, "R1 ovr_flag", ovr_flag, 0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);

        // R2: lengths, LSB first, upper bits zero
        send(8'hA5, 8, 0, 0, 1, 1);
        send(8'h3C, 8, 0, 0, 1, 1);
        send(8'hFF, 5, 0, 0, 1, 1);
        send(8'hEA, 6, 0, 0, 1, 1);
        send(8'hD9, 7, 0, 0, 1, 1);
        drain();
        // R3 / R10: parity rules, good and bad
        send(8'h2B, 6, 1, 0, 1, 1);
        send(8'h2B, 6, 1, 1, 1, 1);
        send(8'h5A, 7, 2, 0, 1, 1);
        send(8'h5B, 7, 2, 1, 1, 1);
        send(8'h81, 8, 3, 0, 1, 1);
        send(8'h81, 8, 3, 1, 1, 1);
        send(8'h0E, 5, 4, 0, 1, 1);
        send(8'h0E, 5, 4, 1, 1, 1);
        send(8'h77, 8, 6, 0, 1, 1);
        drain();
        // R4: framing error with a low stop
        send(8'h81, 8, 0, 0, 0, 1);
        send(8'h42, 8, 1, 1, 0, 1);
        drain();
        // R5: false start
        cfg_len = 2'd3; cfg_par = 3'd0;
        rxd_in = 1'b0;
        repeat (5) @(negedge clk);
        rxd_in = 1'b1;
        repeat (60) @(negedge clk);
        check(rd_valid == 1'b0, "R5 false start stored nothing", rd_valid, 0);
        send(8'h99, 8, 0, 0, 1, 1);
        drain();
        // R6: full break, one entry only
        expq.push_back({8'h00, 1'b0, 1'b0, 1'b1});
        rxd_in = 1'b0;
        repeat (16 * 30) @(negedge clk);
        rxd_in = 1'b1;
        repeat (48) @(negedge clk);
        drain();
        // R6 with parity enabled
        cfg_par = 3'd2;
        expq.push_back({8'h00, 1'b0, 1'b0, 1'b1});
        rxd_in = 1'b0;
        repeat (16 * 14) @(negedge clk);
        rxd_in = 1'b1;
        repeat (48) @(negedge clk);
        drain();
        send(8'h11, 8, 0, 0, 1, 1);
        drain();
        // R7: break beginning after three data bits
        cfg_par = 3'd0; cfg_len = 2'd3;
        expq.push_back({8'h07, 1'b0, 1'b1, 1'b0});
        expq.push_back({8'h00, 1'b0, 1'b0, 1'b1});
        drive_bit(1'b0);
        drive_bit(1'b1); drive_bit(1'b1); drive_bit(1'b1);
        rxd_in = 1'b0;
        repeat (16 * 24) @(negedge clk);
        rxd_in = 1'b1;
        repeat (48) @(negedge clk);
        drain();
        // R8 / R9: fill, overrun, head held
        mon_en = 1'b0;
        send(8'h01, 8, 0, 0, 1, 1);
        send(8'h02, 8, 1, 1, 1, 1);
        send(8'h03, 8, 0, 0, 0, 1);
        send(8'h04, 8, 0, 0, 1, 1);
        check(ovr_flag == 1'b0, "R9 no overrun at four", ovr_flag, 0);
        check(rd_data == 8'h01, "R8 head is oldest", rd_data, 8'h01);
        send(8'h05, 8, 0, 0, 1, 0);
        check(ovr_flag == 1'b1, "R9 overrun set", ovr_flag, 1);
        check(rd_data == 8'h01, "R9 stored entries kept", rd_data, 8'h01);
        mon_en = 1'b1;
        drain();
        repeat (4) @(negedge clk);
        check(rd_valid == 1'b0, "R9 fifth character discarded", rd_valid, 0);
        check(ovr_flag == 1'b1, "R9 overrun sticky", ovr_flag, 1);
        ovr_clr = 1'b1;
        @(negedge clk);
        ovr_clr = 1'b0;
        @(negedge clk);
        check(ovr_flag == 1'b0, "R9 overrun cleared", ovr_flag, 0);
        send(8'hC3, 8, 1, 0, 1, 1);
        drain();

        done = 1'b1;
        finish_run();
    end
endmodule